// File: doc/BRIEF.md
# Cache Set Victim Way Selector

This block chooses which way of a set-associative cache set receives a refill. It keeps a small replacement record for every set: a binary decision tree of direction bits, a round-robin pointer, and the identity of the way touched most recently. The cache controller reports every access, hits and fills alike, with the set and the way. When a lookup misses, it raises the miss strobe together with the set number and the valid bits of that set's ways. One cycle later the block presents the chosen way and a flag. The flag tells whether a live line is displaced or an empty way is being used.

The replacement rule can be switched while the block runs, with a two-bit policy input: 0 random, 1 tree pseudo-LRU, 2 round-robin, 3 round-robin that skips the most recently used way. With two ways the tree has a single node, and that node is exact LRU. A small controller has two states. ST_IDLE has no result on show. ST_SHOW presents a result for one cycle. There are three transitions. GO_SHOW moves from ST_IDLE to ST_SHOW on a miss. HOLD_SHOW keeps ST_SHOW when a second miss follows at once. GO_IDLE returns from ST_SHOW to ST_IDLE when no miss is pending.

Top module: `way_victim_sel`

## Requirements
- R1: After reset no result is shown, every tree bit is zero so the tree policy first picks way 0, every round-robin pointer is at way 0, and no way counts as recently used.
- R2: A miss strobe in cycle n makes pick_valid_o high in cycle n+1, and pick_valid_o is low in any cycle not preceded by a miss strobe.
- R3: When any valid bit of the set is 0, the result is the lowest-numbered invalid way with pick_evict_o = 0, whatever the policy, and no replacement state changes.
- R4: Under policy 1 the victim is found from the root: node k goes to child 2k when its bit is 0 and to child 2k+1 when it is 1. Node 1 is the root and leaf node WAYS+w stands for way w. Each access to way w sets every node on w's path to point away from w, under every policy.
- R5: Under policy 2, with all ways valid, the victim is the set's pointer, and the pointer then advances by one, modulo WAYS.
- R6: Under policy 3, with all ways valid, the victim is the pointer unless the pointer equals the most recently accessed way of the set, in which case the next way is taken. The pointer then moves to one past the victim.
- R7: Under policy 0, with all ways valid, the victim comes from a free-running pseudo-random sequence. pick_evict_o = 1, and neither the pointer nor the tree changes.
- R8: Every set keeps its own tree bits, pointer and recent-way record, and activity in one set leaves the others unchanged.
- R9: A miss with all ways valid under policies 0, 1, 2 or 3 sets pick_evict_o = 1. Policies 0 and 1 leave the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pol_i | input | 2 | Policy: 0 random, 1 tree, 2 round-robin, 3 round-robin skipping MRU |
| set_i | input | $clog2(SETS) | Set addressed by the access or miss |
| acc_i | input | 1 | Access strobe (hit or fill) |
| acc_way_i | input | $clog2(WAYS) | Way touched by the access |
| miss_i | input | 1 | Miss strobe requesting a victim |
| valid_i | input | WAYS | Valid bits of the addressed set's ways |
| pick_valid_o | output | 1 | Result shown this cycle |
| pick_way_o | output | $clog2(WAYS) | Chosen way |
| pick_evict_o | output | 1 | 1 when a valid line is displaced |

## Verification
The assertions assume that the access strobe and the miss strobe are never high in the same cycle. They also assume that WAYS is a power of two, so the pointer wraps on its own. The stimulus keeps within this by choosing one operation per cycle, either an access, a miss or a pause, and never both strobes at once. Sets, ways, policies and valid patterns are drawn at random, with full valid masks favoured so that every policy decision is reached often. Directed sequences cover reset, the empty-way shortcut and the skip of the most recently used way.

// File: rtl/way_victim_pkg.sv
package way_victim_pkg;
    typedef enum logic [1:0] {
        POL_RAND = 2'd0,
        POL_TREE = 2'd1,
        POL_FIFO = 2'd2,
        POL_NMRU = 2'd3
    } pol_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } st_e;
endpackage

// File: rtl/wv_lfsr.sv
module wv_lfsr #(
    parameter int LFSR_W = 16,
    parameter logic [15:0] TAPS = 16'hB400,
    parameter int OUT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd_o
);
    logic [LFSR_W-1:0] lfsr_q;
    logic [LFSR_W-1:0] lfsr_d;

    always_comb begin
        lfsr_d = lfsr_q >> 1;
        if (lfsr_q[0]) lfsr_d = lfsr_d ^ TAPS[LFSR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= LFSR_W'(1);
        else        lfsr_q <= lfsr_d;
    end

    assign rnd_o = lfsr_q[OUT_W-1:0];

    // R7: the sequence never locks up in the all-zero state
    always_ff @(posedge clk) begin
        if (rst_n) a_r7_lfsr_alive: assert (lfsr_q != '0);
    end
endmodule

// File: rtl/wv_plru_tree.sv
module wv_plru_tree #(
    parameter int WAYS = 4,
    localparam int WB = $clog2(WAYS),
    localparam int NODES = WAYS - 1
) (
    input  logic [NODES-1:0] tree_i,
    input  logic [WB-1:0]    acc_way_i,
    output logic [WB-1:0]    victim_o,
    output logic [NODES-1:0] tree_upd_o
);
    function automatic logic [WB-1:0] follow(input logic [NODES-1:0] t);
        int node;
        node = 1;
        for (int l = 0; l < WB; l++) node = 2 * node + int'(t[node-1]);
        return WB'(node - WAYS);
    endfunction

    always_comb begin
        int node;
        logic b;
        victim_o   = follow(tree_i);
        tree_upd_o = tree_i;
        node = 1;
        for (int l = 0; l < WB; l++) begin
            b = acc_way_i[WB-1-l];
            tree_upd_o[node-1] = ~b;
            node = 2 * node + int'(b);
        end
    end

    // R4: after touching a way the tree must never name that way next
    always_comb begin
        a_r4_points_away: assert (follow(tree_upd_o) != acc_way_i);
    end
endmodule

// File: rtl/wv_rr_pick.sv
module wv_rr_pick #(
    parameter int WAYS = 4,
    localparam int WB = $clog2(WAYS)
) (
    input  logic [WB-1:0] ptr_i,
    input  logic [WB-1:0] mru_i,
    input  logic          mru_vld_i,
    input  logic          skip_mru_i,
    output logic [WB-1:0] victim_o
);
    always_comb begin
        if (skip_mru_i && mru_vld_i && (ptr_i == mru_i)) victim_o = ptr_i + WB'(1);
        else                                             victim_o = ptr_i;
    end

    // R6: with skipping enabled the recent way is never the victim
    always_comb begin
        if (skip_mru_i && mru_vld_i) a_r6_skips_recent: assert (victim_o != mru_i);
    end
endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel
    import way_victim_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    parameter int LFSR_W = 16,
    localparam int WB = $clog2(WAYS),
    localparam int SB = $clog2(SETS),
    localparam int NODES = WAYS - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      pol_i,
    input  logic [SB-1:0]   set_i,
    input  logic            acc_i,
    input  logic [WB-1:0]   acc_way_i,
    input  logic            miss_i,
    input  logic [WAYS-1:0] valid_i,
    output logic            pick_valid_o,
    output logic [WB-1:0]   pick_way_o,
    output logic            pick_evict_o
);
    logic [NODES-1:0] tree_q [SETS];
    logic [WB-1:0]    ptr_q  [SETS];
    logic [WB-1:0]    mru_q  [SETS];
    logic [SETS-1:0]  mru_vld_q;

    st_e              st_q, st_d;
    pol_e             pol;
    logic             all_valid;
    logic [WB-1:0]    hole_way;
    logic [WB-1:0]    tree_victim, rr_victim, rnd_way, pick_d;
    logic [NODES-1:0] tree_upd;
    logic             rr_mode;

    assign pol       = pol_e'(pol_i);
    assign all_valid = &valid_i;
    assign rr_mode   = (pol == POL_FIFO) || (pol == POL_NMRU);

    wv_lfsr #(.LFSR_W(LFSR_W), .OUT_W(WB)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd_o (rnd_way)
    );

    wv_plru_tree #(.WAYS(WAYS)) u_tree (
        .tree_i     (tree_q[set_i]),
        .acc_way_i  (acc_way_i),
        .victim_o   (tree_victim),
        .tree_upd_o (tree_upd)
    );

    wv_rr_pick #(.WAYS(WAYS)) u_rr (
        .ptr_i      (ptr_q[set_i]),
        .mru_i      (mru_q[set_i]),
        .mru_vld_i  (mru_vld_q[set_i]),
        .skip_mru_i (pol == POL_NMRU),
        .victim_o   (rr_victim)
    );

    always_comb begin
        hole_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid_i[i]) hole_way = WB'(i);
        end
    end

    always_comb begin
        if (!all_valid) pick_d = hole_way;
        else begin
            unique case (pol)
                POL_RAND: pick_d = rnd_way;
                POL_TREE: pick_d = tree_victim;
                POL_FIFO,
                POL_NMRU: pick_d = rr_victim;
                default:  pick_d = '0;
            endcase
        end
    end

    // Per-set replacement record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                tree_q[s] <= '0;
                ptr_q[s]  <= '0;
                mru_q[s]  <= '0;
            end
            mru_vld_q <= '0;
        end else begin
            if (acc_i) begin
                tree_q[set_i]    <= tree_upd;
                mru_q[set_i]     <= acc_way_i;
                mru_vld_q[set_i] <= 1'b1;
            end
            if (miss_i && all_valid && rr_mode) begin
                ptr_q[set_i] <= rr_victim + WB'(1);
            end
        end
    end

    // Controller: next state
    always_comb begin
        unique case (st_q)
            ST_IDLE: st_d = miss_i ? ST_SHOW : ST_IDLE;
            ST_SHOW: st_d = miss_i ? ST_SHOW : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // Controller: state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Controller: outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pick_way_o   <= '0;
            pick_evict_o <= 1'b0;
        end else if (miss_i) begin
            pick_way_o   <= pick_d;
            pick_evict_o <= all_valid;
        end
    end

    assign pick_valid_o = (st_q == ST_SHOW);

    // Assertions
    always_ff @(posedge clk) begin
        if (rst_n) a_r9_strobes_exclusive: assert (!(acc_i && miss_i));
    end

    a_r2_result_follows_miss: assert property (@(posedge clk) disable iff (!rst_n)
        miss_i |=> pick_valid_o);

    a_r2_quiet_without_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_i |=> !pick_valid_o);

    a_r3_hole_no_evict: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_i && !(&valid_i)) |=> (!pick_evict_o && pick_way_o == $past(hole_way)));

    a_r9_full_set_evicts: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_i && (&valid_i)) |=> pick_evict_o);

    a_r5_pointer_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_i && (&valid_i) && pol_i == 2'd2 && !acc_i)
        |=> ptr_q[$past(set_i)] == $past(ptr_q[set_i]) + WB'(1));
endmodule

// File: tb/way_victim_sel_test.sv
`timescale 1ns/1ps
module way_victim_sel_test;
    localparam int WAYS = 4;
    localparam int SETS = 16;
    localparam int WB = 2;
    localparam int SB = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      pol_i = '0;
    logic [SB-1:0]   set_i = '0;
    logic            acc_i = 1'b0;
    logic [WB-1:0]   acc_way_i = '0;
    logic            miss_i = 1'b0;
    logic [WAYS-1:0] valid_i = '1;
    logic            pick_valid_o;
    logic [WB-1:0]   pick_way_o;
    logic            pick_evict_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit [7:0] m_tree [SETS];
    int       m_ptr  [SETS];
    int       m_mru  [SETS];
    bit       m_mv   [SETS];
    int       rnd_seen;

    always #4 clk = ~clk;

    way_victim_sel #(.WAYS(WAYS), .SETS(SETS)) uut (
        .clk(clk), .rst_n(rst_n), .pol_i(pol_i), .set_i(set_i),
        .acc_i(acc_i), .acc_way_i(acc_way_i), .miss_i(miss_i), .valid_i(valid_i),
        .pick_valid_o(pick_valid_o), .pick_way_o(pick_way_o), .pick_evict_o(pick_evict_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int tree_victim(input int s);
        int node = 1;
        for (int l = 0; l < WB; l++) node = 2 * node + int'(m_tree[s][node]);
        return node - WAYS;
    endfunction

    function automatic int lowest_hole(input logic [WAYS-1:0] v);
        for (int i = 0; i < WAYS; i++) if (!v[i]) return i;
        return -1;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < SETS; s++) begin
            m_tree[s] = '0; m_ptr[s] = 0; m_mru[s] = 0; m_mv[s] = 1'b0;
        end
    endtask

    task automatic do_access(input int s, input int w);
        int node = 1;
        set_i = SB'(s); acc_way_i = WB'(w); acc_i = 1'b1;
        @(posedge clk);
        for (int l = WB - 1; l >= 0; l--) begin
            int b = (w >> l) & 1;
            m_tree[s][node] = (b == 0);
            node = 2 * node + b;
        end
        m_mru[s] = w; m_mv[s] = 1'b1;
        @(negedge clk);
        acc_i = 1'b0;
    endtask

    task automatic do_miss(input int s, input int pol, input logic [WAYS-1:0] v, input string req);
        int exp_way;
        bit exp_ev;
        bit any_way;
        set_i = SB'(s); pol_i = 2'(pol); valid_i = v; miss_i = 1'b1;
        any_way = 1'b0;
        if (lowest_hole(v) >= 0) begin
            exp_way = lowest_hole(v); exp_ev = 1'b0;
        end else begin
            exp_ev = 1'b1;
            case (pol)
                0: begin exp_way = 0; any_way = 1'b1; end
                1: exp_way = tree_victim(s);
                2: begin exp_way = m_ptr[s]; m_ptr[s] = (exp_way + 1) % WAYS; end
                default: begin
                    exp_way = (m_mv[s] && m_ptr[s] == m_mru[s]) ? (m_ptr[s] + 1) % WAYS : m_ptr[s];
                    m_ptr[s] = (exp_way + 1) % WAYS;
                end
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        miss_i = 1'b0;
        check(pick_valid_o == 1'b1, "R2 result shown after miss", int'(pick_valid_o), 1);
        check(pick_evict_o == exp_ev, {req, " evict flag"}, int'(pick_evict_o), int'(exp_ev));
        if (any_way) rnd_seen |= (1 << pick_way_o);
        else check(int'(pick_way_o) == exp_way, {req, " way"}, int'(pick_way_o), exp_way);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        rnd_seen = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(pick_valid_o == 1'b0, "R1 no result after reset", int'(pick_valid_o), 0);
        do_miss(0, 1, '1, "R1 tree starts at way 0");
        do_miss(1, 2, '1, "R1 pointer starts at way 0");
        // R2: no miss -> no result
        @(negedge clk);
        check(pick_valid_o == 1'b0, "R2 quiet without miss", int'(pick_valid_o), 0);
        // R3: hole wins over every policy and leaves pointer alone
        do_miss(2, 2, 4'b1011, "R3 lowest invalid way");
        do_miss(2, 3, 4'b0110, "R3 lowest invalid way");
        do_miss(2, 2, '1, "R3 pointer untouched by hole fill");
        // R4: tree follows accesses
        do_access(4, 0); do_access(4, 2);
        do_miss(4, 1, '1, "R4 tree victim");
        do_access(4, 1);
        do_miss(4, 1, '1, "R4 tree victim");
        // R6: skip recent way
        do_access(5, 0);
        do_miss(5, 3, '1, "R6 skip recent way");
        do_access(5, 2);
        do_miss(5, 3, '1, "R6 skip recent way");
        // R5: round-robin wraps
        for (int i = 0; i < 5; i++) do_miss(6, 2, '1, "R5 round-robin order");
        // R8: other set still at start
        do_miss(7, 2, '1, "R8 sets independent");
        // R7: random choices vary and leave pointer
        for (int i = 0; i < 40; i++) do_miss(6, 0, '1, "R7 random evicts");
        check(rnd_seen != 0 && (rnd_seen & (rnd_seen - 1)) != 0, "R7 random spread", rnd_seen, 15);
        do_miss(6, 2, '1, "R9 pointer kept across random");
        // Back-to-back misses
        set_i = 4'd8; pol_i = 2'd2; valid_i = '1; miss_i = 1'b1;
        @(posedge clk); m_ptr[8] = 1;
        @(negedge clk);
        do_miss(8, 2, '1, "R2 back-to-back miss");
        // Random mix
        for (int n = 0; n < 600; n++) begin
            int op = $urandom_range(0, 9);
            int s = $urandom_range(0, 5);
            if (op < 4) do_access(s, $urandom_range(0, WAYS - 1));
            else if (op < 9) begin
                logic [WAYS-1:0] v = ($urandom_range(0, 4) == 0) ? WAYS'($urandom) : '1;
                do_miss(s, $urandom_range(0, 3), v, "R8 random mix");
            end else begin
                @(negedge clk);
                check(pick_valid_o == 1'b0, "R2 quiet without miss", int'(pick_valid_o), 0);
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule